// File: doc/BRIEF.md
# Colour Subframe Duty Modulator

This block converts one packed colour pixel into three on/off subpixel bits for a passive colour panel. Such a panel can only switch each subpixel fully on or fully off in a given frame. Intermediate intensities are therefore built up over a cycle of eight subframes. In each subframe, a subpixel is lit when its colour code is strictly greater than a shared 3-bit subframe index.

The pixel byte carries three bits of red, three bits of green and two bits of blue. Blue is widened to three bits by repeating its upper bit below it. The block also holds the subframe index. The index advances once for each frame-start strobe from the display timing logic and wraps from 7 back to 0.

Pixels enter on a valid/ready stream and leave on a valid/ready stream. The path is combinational: the output valid follows the input valid, the input ready follows the output ready, and the colour bits follow the input byte in the same cycle. Back-pressure passes straight through. While the output ready is low, the input is not accepted, and the upstream source must hold its byte and valid asserted until the transfer completes.

Top module: `frc_modulator`

## Requirements
- R1: After reset the subframe index reads 0.
- R2: Each cycle with frame_start high advances the subframe index by one, and the index wraps from 7 to 0. Cycles with frame_start low leave the index unchanged.
- R3: Red is lit exactly when pixel bits 7:5, taken as an unsigned number, are greater than the subframe index.
- R4: Green is lit exactly when pixel bits 4:2, taken as an unsigned number, are greater than the subframe index.
- R5: Blue is lit exactly when the 3-bit value {bits 1:0, bit 1} is greater than the subframe index. Over one cycle of eight subframes this gives 0, 2, 5 and 7 lit subframes for blue codes 0 to 3.
- R6: A colour code of 0 is never lit. The largest code is lit in 7 of the 8 subframes.
- R7: out_valid equals in_valid and in_ready equals out_ready in the same cycle, with no added latency. The colour bits depend only on the current byte and the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of each display frame |
| in_valid | input | 1 | Pixel byte valid |
| in_ready | output | 1 | Pixel byte accepted when high together with in_valid |
| in_pixel | input | 8 | Packed pixel: red 7:5, green 4:2, blue 1:0 |
| out_valid | output | 1 | Subpixel bits valid |
| out_ready | input | 1 | Downstream can take the subpixel bits |
| out_rgb | output | 3 | Subpixel on bits: red in bit 2, green in bit 1, blue in bit 0 |
| subframe | output | 3 | Current subframe index |

## Verification
The assertions check two things on every cycle. First, the subframe index holds or steps by exactly one according to the strobe, and it wraps correctly. Second, the handshake passes straight through, and a zero code never lights a subpixel. The per-channel thresholds and the duty counts over a whole modulation cycle can only be shown by the bench. It sweeps every pixel byte against every subframe index and counts the lit subframes for each code.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int CNT_W = 3;
  localparam int RG_W  = 3;
  localparam int B_W   = 2;
  localparam int PIX_W = 2 * RG_W + B_W;
  localparam int RED_LSB = RG_W + B_W;
  localparam int GRN_LSB = B_W;
  typedef logic [CNT_W-1:0] sub_t;
endpackage

// File: rtl/frc_subframe_counter.sv
module frc_subframe_counter
  import frc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output sub_t count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (step) count <= count + 1'b1;
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == sub_t'($past(count) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));
endmodule

// File: rtl/frc_channel_cmp.sv
module frc_channel_cmp
  import frc_pkg::*;
#(
  parameter int IN_W = 3
) (
  input  logic [IN_W-1:0] code,
  input  sub_t            phase,
  output logic            lit
);
  sub_t scaled;
  generate
    if (IN_W >= CNT_W) begin : g_trunc
      assign scaled = code[IN_W-1 -: CNT_W];
    end else begin : g_widen
      assign scaled = {code, code[IN_W-1 -: (CNT_W-IN_W)]};
    end
  endgenerate
  assign lit = scaled > phase;

  always_comb begin
    assert_zero_dark_R6: assert (!(code == '0 && lit));
  end
endmodule

// File: rtl/frc_modulator.sv
module frc_modulator
  import frc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_rgb,
  output logic [CNT_W-1:0] subframe
);
  sub_t phase;

  frc_subframe_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .step(frame_start), .count(phase)
  );

  frc_channel_cmp #(.IN_W(RG_W)) u_red (
    .code(in_pixel[RED_LSB +: RG_W]), .phase(phase), .lit(out_rgb[2])
  );
  frc_channel_cmp #(.IN_W(RG_W)) u_grn (
    .code(in_pixel[GRN_LSB +: RG_W]), .phase(phase), .lit(out_rgb[1])
  );
  frc_channel_cmp #(.IN_W(B_W)) u_blu (
    .code(in_pixel[B_W-1:0]), .phase(phase), .lit(out_rgb[0])
  );

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign subframe  = phase;

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));
  assert_max_lit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (subframe == 3'd7) |-> (out_rgb == 3'b000));
endmodule

// File: tb/frc_modulator_tb.sv
module frc_modulator_tb;
  logic clk = 0, rst_n = 0, frame_start = 0, in_valid = 0, out_ready = 0;
  logic [7:0] in_pixel = 0;
  logic in_ready, out_valid;
  logic [2:0] out_rgb, subframe;
  int checks = 0, fails = 0;
  int duty_b [4];
  int duty_r [8];

  always #4 clk = ~clk;

  frc_modulator u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", subframe, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", subframe, 0);
    repeat (5) @(negedge clk);
    chk("R2 hold", subframe, 0);

    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 256; p++) begin
        in_pixel = p[7:0];
        #1;
        chk("R3", out_rgb[2], int'((p >> 5) > (s % 8)));
        chk("R4", out_rgb[1], int'(((p >> 2) & 7) > (s % 8)));
        chk("R5", out_rgb[0], int'((((p & 3) << 1) | ((p >> 1) & 1)) > (s % 8)));
        if (s < 8 && (p & 8'h1c) == 0) begin
          duty_r[p >> 5] += out_rgb[2];
          if ((p >> 5) == 0) duty_b[p & 3] += out_rgb[0];
        end
      end
      strobe();
      chk("R2 step", subframe, (s + 1) % 8);
    end

    for (int c = 0; c < 8; c++) chk("R6 red duty", duty_r[c], c * 4);
    chk("R5 blue duty0", duty_b[0], 0);
    chk("R5 blue duty1", duty_b[1], 2);
    chk("R5 blue duty2", duty_b[2], 5);
    chk("R5 blue duty3", duty_b[3], 7);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = k[0];
      out_ready = k[1];
      #1;
      chk("R7 valid", out_valid, k[0]);
      chk("R7 ready", in_ready, k[1]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule